// File: doc/BRIEF.md
# Split-Capable Auto-Reload Timer

This block is a count-up timer whose 16-bit counter restarts from a programmable reload value each time it rolls past its all-ones state. A control bit splits it at run time into two 8-bit timers, the low byte and the high byte. Each byte then counts on its own, restarts from its own reload byte and raises its own overflow flag. Software reaches the control word, the two count bytes and the two reload bytes through a simple byte-wide write port and a combinational read port.

Counting advances on ticks from one of three sources: every system clock, one system clock in twelve, or one tick per eight edges of an external oscillator. The oscillator divider runs in its own clock domain, and its ticks cross into the system domain through a synchronizer before they touch any readable state. While the suspend input is high, the two system-derived sources stop. The oscillator source keeps counting, and an overflow in that state raises a wake request that stays up until software clears the flags.

Top module: `reload_timer`

## Requirements
- R1: With the split bit clear, each tick adds one to the 16-bit count. A tick at 0xFFFF loads the 16-bit reload value and sets the high flag (control bit 7). The low flag (control bit 6) is not touched.
- R2: With the split bit (control bit 1) set, the low and high bytes each add one per tick with no carry between them. A byte at 0xFF loads its own reload byte and sets its own flag: the low byte sets bit 6 and the high byte sets bit 7.
- R3: Control bits 3:2 pick the source. 0 gives every system clock. 1 gives one tick on every 12th rising edge counted from reset release. 2 gives the external divider. 3 gives no ticks.
- R4: Source 2 produces one tick per 8 rising edges of ext_clk, passed through a synchronizer into the system domain. It keeps counting while suspend is high.
- R5: With the run bit (control bit 0) at zero, the count does not change. While suspend is high, sources 0 and 1 produce no ticks.
- R6: A write to address 1 (count low) or address 2 (count high) loads that byte at the next clock edge. In that cycle the count does not advance and no flag is set.
- R7: A write to address 0 clears a flag whose data bit is 0 and leaves a flag whose data bit is 1. An overflow in the same cycle sets the flag regardless.
- R8: The wake output rises after an overflow that occurs while suspend is high. It stays high until both flags are zero.
- R9: The register map is as follows. Address 0 is control: run bit 0, split bit 1, source bits 3:2, low flag bit 6, high flag bit 7, bits 5:4 read as zero. Address 1 is count low, 2 is count high, 3 is reload low and 4 is reload high. Every register resets to zero. Other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ext_clk | input | 1 | External oscillator clock |
| suspend | input | 1 | High while the core is suspended |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr, combinational |
| flag_lo | output | 1 | Low-byte overflow flag |
| flag_hi | output | 1 | High or 16-bit overflow flag |
| wake | output | 1 | Wake request |

## Verification
The assertions that a synchronized tick lasts one cycle assume that ext_clk is slow enough for each eight-edge toggle to last several system clocks. The bench runs ext_clk at 14 ns against the 4 ns system clock, which meets this. The exact oscillator tick cycle is not predictable from the ports. For that reason the random phase never selects source 2, so a cycle-exact reference model can follow it. The oscillator source is covered by directed runs that check flags and wake exactly and check the count against a range.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CHI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RHI  = 3'd4;

  localparam int BIT_RUN   = 0;
  localparam int BIT_SPLIT = 1;
  localparam int BIT_SRC   = 2;
  localparam int BIT_FLO   = 6;
  localparam int BIT_FHI   = 7;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_SYS12 = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic split;
    logic run;
  } ctrl_t;

  // one byte step: {wrapped, next value}
  function automatic logic [BYTE_W:0] byte_step(input logic [BYTE_W-1:0] cur,
                                                input logic [BYTE_W-1:0] rld);
    if (&cur) return {1'b1, rld};
    return {1'b0, cur + 1'b1};
  endfunction

  // one full-width step: {wrapped, next value}
  function automatic logic [CNT_W:0] word_step(input logic [CNT_W-1:0] cur,
                                               input logic [CNT_W-1:0] rld);
    if (&cur) return {1'b1, rld};
    return {1'b0, cur + 1'b1};
  endfunction
endpackage

// File: rtl/sys_prescaler.sv
module sys_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;

  assign tick = (div_q == DW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  AST_PRESCALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
endmodule

// File: rtl/ext_tick_sync.sv
module ext_tick_sync #(
  parameter int DIV    = 8,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0]   dcnt_q;
  logic            tog_q;
  logic [STAGES:0] sy_q;

  // oscillator domain: toggle once per DIV edges
  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      tog_q  <= 1'b0;
    end else if (dcnt_q == DW'(DIV - 1)) begin
      dcnt_q <= '0;
      tog_q  <= ~tog_q;
    end else begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  // system domain: synchronizer plus one history bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy_q <= '0;
    else        sy_q <= {sy_q[STAGES-1:0], tog_q};
  end

  assign tick = sy_q[STAGES] ^ sy_q[STAGES-1];

  AST_EXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R4
endmodule

// File: rtl/timer_core.sv
module timer_core
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              split,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [CNT_W-1:0]  rld,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W:0]   lo_s, hi_s;
  logic [CNT_W:0]    w_s;
  logic              hold;

  assign hold = wr_lo | wr_hi;
  assign lo_s = byte_step(cnt_q[BYTE_W-1:0], rld[BYTE_W-1:0]);
  assign hi_s = byte_step(cnt_q[CNT_W-1:BYTE_W], rld[CNT_W-1:BYTE_W]);
  assign w_s  = word_step(cnt_q, rld);

  always_comb begin
    cnt_n  = cnt_q;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    if (hold) begin
      if (wr_lo) cnt_n[BYTE_W-1:0]     = wr_byte;
      if (wr_hi) cnt_n[CNT_W-1:BYTE_W] = wr_byte;
    end else if (adv) begin
      if (split) begin
        cnt_n  = {hi_s[BYTE_W-1:0], lo_s[BYTE_W-1:0]};
        ovf_lo = lo_s[BYTE_W];
        ovf_hi = hi_s[BYTE_W];
      end else begin
        cnt_n  = w_s[CNT_W-1:0];
        ovf_hi = w_s[CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  AST_WORD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hi && !split) |=> (cnt_q == $past(rld))); // R1
  AST_SPLIT_LO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_lo && split) |=> (cnt_q[BYTE_W-1:0] == $past(rld[BYTE_W-1:0]))); // R2
  AST_WRITE_HOLDS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(cnt_q[CNT_W-1:BYTE_W])); // R6
  AST_WRITE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !(ovf_lo || ovf_hi)); // R6
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import tmr_pkg::*;
#(
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              suspend,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              flag_lo,
  output logic              flag_hi,
  output logic              wake
);
  ctrl_t            ctrl_q;
  logic             flo_q, fhi_q, wake_q;
  logic             flo_n, fhi_n, wake_n;
  logic [CNT_W-1:0] rld_q, cnt;
  logic             tick12, ext_tick, src_tick, adv;
  logic             ovf_lo_evt, ovf_hi_evt, ovf_any;
  logic             wr_ctrl, wr_clo, wr_chi, wr_rlo, wr_rhi;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_clo  = wr_en && (wr_addr == A_CLO);
  assign wr_chi  = wr_en && (wr_addr == A_CHI);
  assign wr_rlo  = wr_en && (wr_addr == A_RLO);
  assign wr_rhi  = wr_en && (wr_addr == A_RHI);

  sys_prescaler #(.DIV(SYS_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick12)
  );

  ext_tick_sync #(.DIV(EXT_DIV), .STAGES(SYNC_STAGES)) u_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_clk(ext_clk),
    .tick   (ext_tick)
  );

  always_comb begin
    case (ctrl_q.src)
      SRC_SYS:   src_tick = !suspend;
      SRC_SYS12: src_tick = tick12 && !suspend;
      SRC_EXT:   src_tick = ext_tick;
      default:   src_tick = 1'b0;
    endcase
  end

  assign adv = ctrl_q.run && src_tick;

  timer_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .split  (ctrl_q.split),
    .wr_lo  (wr_clo),
    .wr_hi  (wr_chi),
    .wr_byte(wr_data),
    .rld    (rld_q),
    .cnt    (cnt),
    .ovf_lo (ovf_lo_evt),
    .ovf_hi (ovf_hi_evt)
  );

  assign ovf_any = ovf_lo_evt || ovf_hi_evt;

  always_comb begin
    flo_n = (flo_q && !(wr_ctrl && !wr_data[BIT_FLO])) || ovf_lo_evt;
    fhi_n = (fhi_q && !(wr_ctrl && !wr_data[BIT_FHI])) || ovf_hi_evt;
    if (ovf_any && suspend) wake_n = 1'b1;
    else if (!flo_n && !fhi_n) wake_n = 1'b0;
    else wake_n = wake_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flo_q  <= 1'b0;
      fhi_q  <= 1'b0;
      wake_q <= 1'b0;
      rld_q  <= '0;
    end else begin
      flo_q  <= flo_n;
      fhi_q  <= fhi_n;
      wake_q <= wake_n;
      if (wr_ctrl) begin
        ctrl_q.run   <= wr_data[BIT_RUN];
        ctrl_q.split <= wr_data[BIT_SPLIT];
        ctrl_q.src   <= src_e'(wr_data[BIT_SRC+1:BIT_SRC]);
      end
      if (wr_rlo) rld_q[BYTE_W-1:0]     <= wr_data;
      if (wr_rhi) rld_q[CNT_W-1:BYTE_W] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[BIT_RUN]              = ctrl_q.run;
        rd_data[BIT_SPLIT]            = ctrl_q.split;
        rd_data[BIT_SRC+1:BIT_SRC]    = ctrl_q.src;
        rd_data[BIT_FLO]              = flo_q;
        rd_data[BIT_FHI]              = fhi_q;
      end
      A_CLO:   rd_data = cnt[BYTE_W-1:0];
      A_CHI:   rd_data = cnt[CNT_W-1:BYTE_W];
      A_RLO:   rd_data = rld_q[BYTE_W-1:0];
      A_RHI:   rd_data = rld_q[CNT_W-1:BYTE_W];
      default: rd_data = '0;
    endcase
  end

  assign flag_lo = flo_q;
  assign flag_hi = fhi_q;
  assign wake    = wake_q;

  AST_FREEZE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !wr_clo && !wr_chi) |=> $stable(cnt)); // R5
  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && ctrl_q.src != SRC_EXT && !wr_clo && !wr_chi) |=> $stable(cnt)); // R5
  AST_NO_LO_FLAG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.split && !flo_q) |=> !flo_q); // R1
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hi_evt |=> fhi_q); // R7
  AST_WAKE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && ovf_any) |=> wake_q); // R8
  AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (flo_q || fhi_q)); // R8
endmodule

// File: tb/sim_reload_timer.sv
`timescale 1ns/1ps
module sim_reload_timer;
  logic       clk = 1'b0, ext_clk = 1'b0, rst_n = 1'b0, suspend = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       flag_lo, flag_hi, wake;

  int n_chk = 0, n_bad = 0;
  logic mon_on = 1'b0, ext_phase = 1'b0, done = 1'b0;

  always #2 clk = ~clk;
  always #7 ext_clk = ~ext_clk;

  reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .suspend(suspend),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_lo(flag_lo), .flag_hi(flag_hi), .wake(wake)
  );

  // reference model, restated from the requirements
  logic        m_run = 0, m_split = 0, m_flo = 0, m_fhi = 0, m_wake = 0;
  logic [1:0]  m_sel = 0;
  logic [15:0] m_cnt = 0, m_rld = 0;
  int          m_edge = 0;

  always @(posedge clk) begin : model
    logic t, ol, oh, fl, fh, wlo, whi, wc, on12;
    logic [15:0] c;
    if (!rst_n) begin
      m_run <= 0; m_split <= 0; m_sel <= 0; m_flo <= 0; m_fhi <= 0;
      m_wake <= 0; m_cnt <= 0; m_rld <= 0; m_edge <= 0;
    end else begin
      on12 = ((m_edge + 1) % 12 == 0);   // R3: 12th, 24th ... edge after release
      m_edge <= m_edge + 1;
      case (m_sel)
        2'd0: t = !suspend;
        2'd1: t = on12 && !suspend;
        default: t = 1'b0;
      endcase
      wlo = wr_en && wr_addr == 3'd1;
      whi = wr_en && wr_addr == 3'd2;
      wc  = wr_en && wr_addr == 3'd0;
      c = m_cnt; ol = 0; oh = 0;
      if (wlo || whi) begin
        if (wlo) c[7:0]  = wr_data;
        if (whi) c[15:8] = wr_data;
      end else if (m_run && t) begin
        if (m_split) begin
          if (c[7:0] == 8'hFF) begin c[7:0] = m_rld[7:0]; ol = 1; end
          else c[7:0] = c[7:0] + 8'd1;
          if (c[15:8] == 8'hFF) begin c[15:8] = m_rld[15:8]; oh = 1; end
          else c[15:8] = c[15:8] + 8'd1;
        end else begin
          if (c == 16'hFFFF) begin c = m_rld; oh = 1; end
          else c = c + 16'd1;
        end
      end
      fl = (m_flo && !(wc && !wr_data[6])) || ol;
      fh = (m_fhi && !(wc && !wr_data[7])) || oh;
      if ((ol || oh) && suspend) m_wake <= 1;
      else if (!fl && !fh) m_wake <= 0;
      m_flo <= fl; m_fhi <= fh; m_cnt <= c;
      if (wc) begin m_run <= wr_data[0]; m_split <= wr_data[1]; m_sel <= wr_data[3:2]; end
      if (wr_en && wr_addr == 3'd3) m_rld[7:0]  <= wr_data;
      if (wr_en && wr_addr == 3'd4) m_rld[15:8] <= wr_data;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {m_fhi, m_flo, 2'b00, m_sel, m_split, m_run};
      3'd1: return m_cnt[7:0];
      3'd2: return m_cnt[15:8];
      3'd3: return m_rld[7:0];
      3'd4: return m_rld[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_on && !ext_phase && rst_n) begin
      chk("R9 R1 R2 R6 read port vs model", {8'h00, rd_data}, {8'h00, exp_rd(rd_addr)});
      chk("R7 R2 flags vs model", {14'd0, flag_hi, flag_lo}, {14'd0, m_fhi, m_flo});
      chk("R8 wake vs model", {15'd0, wake}, {15'd0, m_wake});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo); rd(3'd2, hi); v = {hi, lo};
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v8;
    logic [15:0] v16;
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v8);
      chk("R9 reset register value", {8'h00, v8}, 16'h0000);
    end
    chk("R9 reset flags and wake", {13'd0, wake, flag_hi, flag_lo}, 16'h0000);
    @(negedge clk);
    mon_on = 1;

    // R1: 16-bit rollover
    wr(3'd3, 8'h34); wr(3'd4, 8'h12); wr(3'd1, 8'hFD); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h01);
    step(3);
    rd16(v16);
    chk("R1 count reloaded after 0xFFFF", v16, 16'h1234);
    chk("R1 high flag set, low flag clear", {14'd0, flag_hi, flag_lo}, 16'h0002);
    @(negedge clk);
    // R7: writing ones keeps flags
    wr(3'd0, 8'hC0);
    rd(3'd0, v8);
    chk("R7 flag kept by write of one", {8'h00, v8}, 16'h0080);
    @(negedge clk);
    wr(3'd0, 8'h00);
    rd(3'd0, v8);
    chk("R7 flag cleared by write of zero", {8'h00, v8}, 16'h0000);

    // R2: split mode
    @(negedge clk);
    wr(3'd3, 8'hA0); wr(3'd4, 8'h50); wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h03);
    step(2);
    rd16(v16);
    chk("R2 split bytes reload independently", v16, 16'h51A0);
    chk("R2 both byte flags set", {14'd0, flag_hi, flag_lo}, 16'h0003);
    @(negedge clk);
    wr(3'd0, 8'h02);

    // R3: divide-by-12 gives exactly 2 ticks in 24 edges; source 3 gives none
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h05);
    step(24);
    rd16(v16);
    chk("R3 sys/12 tick count over 24 cycles", v16, 16'h0002);
    @(negedge clk);
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h0D);
    step(20);
    rd16(v16);
    chk("R3 source 3 produces no ticks", v16, 16'h0000);

    // R5: run=0 and suspend freeze
    @(negedge clk);
    wr(3'd1, 8'h55); wr(3'd2, 8'hAA); wr(3'd0, 8'h00);
    step(10);
    rd16(v16);
    chk("R5 run bit zero freezes count", v16, 16'hAA55);
    @(negedge clk);
    suspend = 1;
    wr(3'd0, 8'h01);
    step(10);
    rd16(v16);
    chk("R5 suspend freezes system source", v16, 16'hAA55);
    @(negedge clk);
    wr(3'd0, 8'h05);
    step(30);
    rd16(v16);
    chk("R5 suspend freezes sys/12 source", v16, 16'hAA55);
    @(negedge clk);
    suspend = 0;
    wr(3'd0, 8'h00);

    // R6: count writes while running
    wr(3'd0, 8'h01); wr(3'd2, 8'h40); wr(3'd1, 8'hF0);
    rd16(v16);
    chk("R6 written bytes with no advance", v16, 16'h40F0);
    @(negedge clk);
    rd16(v16);
    chk("R6 counting resumes next cycle", v16, 16'h40F1);
    @(negedge clk);
    wr(3'd0, 8'h00);

    // R9: unmapped address
    wr(3'd5, 8'hFF);
    rd(3'd5, v8);
    chk("R9 unmapped address reads zero", {8'h00, v8}, 16'h0000);
    rd(3'd0, v8);
    chk("R9 unmapped write leaves control", {8'h00, v8}, 16'h0000);

    // R4/R8: external source under suspend
    @(negedge clk);
    ext_phase = 1;
    wr(3'd3, 8'h00); wr(3'd4, 8'h01); wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    suspend = 1;
    wr(3'd0, 8'h09);
    step(200);
    rd16(v16);
    chk("R4 ext source counts during suspend", {15'd0, (v16 >= 16'h0100 && v16 <= 16'h0108)}, 16'h0001);
    chk("R4 ext overflow sets high flag only", {14'd0, flag_hi, flag_lo}, 16'h0002);
    chk("R8 wake after suspended overflow", {15'd0, wake}, 16'h0001);
    @(negedge clk);
    wr(3'd0, 8'hCC);
    step(10);
    chk("R8 wake held while flag set", {15'd0, wake}, 16'h0001);
    wr(3'd0, 8'h00);
    chk("R8 wake drops when flags clear", {15'd0, wake}, 16'h0000);
    suspend = 0;
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd0, 8'h09);
    step(100);
    chk("R4 ext overflow without suspend", {15'd0, flag_hi}, 16'h0001);
    chk("R8 no wake without suspend", {15'd0, wake}, 16'h0000);
    wr(3'd0, 8'hCC);
    step(10);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    ext_phase = 0;

    // random phase, sources 0, 1, 3 only
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_addr = 3'($urandom_range(0, 5));
      d       = 8'($urandom);
      if (wr_addr == 3'd0) begin
        if (d[3:2] == 2'b10) d[3:2] = 2'b00;
        d[0] = ($urandom_range(0, 3) != 0);
      end
      if ((wr_addr == 3'd1 || wr_addr == 3'd2) && $urandom_range(0, 1) == 1) d[7:4] = 4'hF;
      wr_data = d;
      rd_addr = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 15) == 0) suspend = ~suspend;
      @(negedge clk);
    end
    wr_en = 0; suspend = 0;
    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule